// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer with Latency Pipeline

This block is the column-side burst engine of a synchronous DRAM device model. It takes a decoded command, the address bus, the per-byte mask pins and the write data. A mode-set command loads a small mode register from the low address bits, which selects the burst length, the wrap order and the read latency. A read or write command starts a burst at an 8-bit column. The block then issues one column address per clock until the burst ends or another command cuts it short. The page is a plain register array of 2^COL_W words.

Writes take effect with zero latency: the data and the byte enables on the same clock as each column are stored at that edge. Reads are fetched in the beat cycle and come out after the programmed latency. A byte mask sampled two clocks earlier decides which bytes are driven. A precharge ends any burst, and read data already in flight stops at a point that depends on the latency. The read data leaves as a valid-qualified stream. It has no ready input, because a memory device cannot hold back its data pins. Data is lost unless the consumer accepts it in the cycle it is valid.

Top module: `burst_col_engine`

## Requirements
- R1: `cmd` encodes 0 = no-op, 1 = mode set, 2 = read, 3 = write, 4 = precharge, and other values act as no-op. After reset all outputs are low, and the mode is burst length 4, sequential order, latency 2.
- R2: On a mode set, `addr[2:0]` selects the burst length (000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = whole page), `addr[3]` selects the order (0 sequential, 1 interleave), and `addr[6:4]` selects the read latency (001 = 1, 010 = 2, 011 = 3).
- R3: A mode set that carries a reserved length code (100, 101, 110), a reserved latency code (000, 1xx), or whole-page length with interleave order is ignored entirely, and the previous mode stays in force.
- R4: In the cycle of a read or write command, `col_valid` is high and `col_addr` equals `addr`. The burst then yields one column per clock, for as many beats as the burst length.
- R5: In sequential order, beat k addresses the aligned block of burst-length columns that holds the start column, at offset (start + k) mod length.
- R6: In interleave order, beat k addresses the same aligned block, at offset (start XOR k).
- R7: A whole-page burst steps sequentially through all 2^COL_W columns, wraps from the top column to column 0, and continues until a new command or a precharge ends it.
- R8: In each write beat, `wr_strobe[b]` is high exactly when `dqm[b]` is low in that cycle, and byte b of `wdata` is stored at that edge (byte 0 = bits 7:0, byte 1 = bits 15:8).
- R9: The word read in a beat cycle appears on `rdata`, with `rd_valid` high, exactly CL cycles later, where CL is the programmed latency.
- R10: When `rd_valid` is high, `rd_oe[b]` equals the inverse of `dqm[b]` from two cycles earlier, whatever the latency. An undriven byte of `rdata` reads zero.
- R11: A read or write command issued during a burst ends that burst at once and starts a new one. Commands may be on consecutive clocks, and read data already issued is still delivered.
- R12: A precharge in cycle p yields no column beat in cycle p and ends the burst. No read data from before p appears in cycle p+2 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Decoded command code |
| addr | input | COL_W | Start column, or mode key on a mode set |
| dqm | input | NB | Byte mask, one bit per byte |
| wdata | input | DATA_W | Write data, same clock as its beat |
| col_valid | output | 1 | A column beat occurs this cycle |
| col_addr | output | COL_W | Column of this beat |
| wr_strobe | output | NB | Per-byte write enable of this beat |
| rd_valid | output | 1 | Read data is due this cycle |
| rd_oe | output | NB | Per-byte output drive enable |
| rdata | output | DATA_W | Read data, undriven bytes zero |

## Verification
Column address, `col_valid` and `wr_strobe` follow the command in the same cycle. Read data is due CL cycles after its beat, and the byte drive enables follow the mask with a fixed two-cycle delay. After a precharge, nothing may emerge from the third cycle on. The bench builds per-cycle stimulus and expected tables before each run, placing each read result at beat cycle plus CL and each enable at mask cycle plus two. It drives inputs on the falling edge and samples one nanosecond later, so every registered result is compared in the cycle it is due. The runs sweep both wrap orders, every fixed length, four start columns and all three latencies, and add whole-page wrap, mid-burst interruption, precharge cut-off per latency and rejected mode keys.

// File: rtl/bce_pkg.sv
`timescale 1ns/1ps
package bce_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MODE  = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4
  } cmd_e;

  typedef struct packed {
    logic       full;  // whole-page burst
    logic [1:0] lg;    // log2 of burst length when not full
    logic       ilv;   // interleave order
    logic [1:0] cl;    // read latency 1..3
  } mode_t;

  localparam mode_t MODE_RST = '{full: 1'b0, lg: 2'd2, ilv: 1'b0, cl: 2'd2};
endpackage

// File: rtl/bce_mode_reg.sv
`timescale 1ns/1ps
module bce_mode_reg
  import bce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [6:0] key,
  output mode_t      mode
);
  mode_t nxt;
  logic  legal;

  always_comb begin
    nxt   = mode;
    legal = 1'b1;
    nxt.ilv = key[3];
    case (key[2:0])
      3'b000, 3'b001, 3'b010, 3'b011: begin
        nxt.full = 1'b0;
        nxt.lg   = key[1:0];
      end
      3'b111: begin
        nxt.full = 1'b1;
        nxt.lg   = 2'd0;
        legal    = ~key[3];   // whole page only in sequential order (R3)
      end
      default: legal = 1'b0;
    endcase
    case (key[6:4])
      3'b001, 3'b010, 3'b011: nxt.cl = key[5:4];
      default:                legal  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mode <= MODE_RST;
    else if (wr_en && legal) mode <= nxt;
  end
endmodule

// File: rtl/bce_col_gen.sv
`timescale 1ns/1ps
module bce_col_gen
  import bce_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  mode_t            mode,
  output logic             beat,
  output logic             beat_wr,
  output logic [COL_W-1:0] col
);
  logic             active_q, wr_q;
  logic [COL_W-1:0] base_q, cnt_q;
  logic [COL_W-1:0] mask, cur_base, cur_cnt, off;
  logic             cur_wr;

  always_comb begin
    mask = mode.full ? {COL_W{1'b1}} : COL_W'((1 << mode.lg) - 1);
    if (start_rd || start_wr) begin
      cur_base = start_col;
      cur_cnt  = '0;
      cur_wr   = start_wr;
      beat     = 1'b1;
    end else begin
      cur_base = base_q;
      cur_cnt  = cnt_q;
      cur_wr   = wr_q;
      beat     = active_q & ~stop;
    end
    off     = mode.ilv ? (cur_base ^ cur_cnt) : (cur_base + cur_cnt);
    col     = (cur_base & ~mask) | (off & mask);
    beat_wr = beat & cur_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (beat) begin
      base_q   <= cur_base;
      wr_q     <= cur_wr;
      cnt_q    <= cur_cnt + 1'b1;
      active_q <= mode.full | (cur_cnt != mask);
    end else begin
      active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bce_rd_pipe.sv
`timescale 1ns/1ps
module bce_rd_pipe #(
  parameter  int DATA_W   = 16,
  parameter  int MAX_LAT  = 3,
  parameter  int MASK_LAT = 2,
  localparam int NB       = DATA_W / 8,
  localparam int LAT_W    = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NB-1:0]     dqm,
  input  logic              kill,
  input  logic [LAT_W-1:0]  lat,
  output logic              out_valid,
  output logic [NB-1:0]     out_oe,
  output logic [DATA_W-1:0] out_data
);
  logic [MAX_LAT-1:0] v_q;
  logic [DATA_W-1:0]  d_q  [MAX_LAT];
  logic [NB-1:0]      dm_q [MASK_LAT];
  logic [LAT_W-1:0]   tap;
  logic [DATA_W-1:0]  tap_data;

  // Stage j feeds the output j+1 cycles after capture; on a precharge every
  // entry that would surface later than the next cycle is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MAX_LAT; j++) begin
        v_q[j] <= 1'b0;
        d_q[j] <= '0;
      end
    end else begin
      v_q[0] <= in_valid & ~(kill && (1 < int'(lat)));
      d_q[0] <= in_data;
      for (int j = 1; j < MAX_LAT; j++) begin
        v_q[j] <= v_q[j-1] & ~(kill && (j + 1 < int'(lat)));
        d_q[j] <= d_q[j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MASK_LAT; j++) dm_q[j] <= '0;
    end else begin
      dm_q[0] <= dqm;
      for (int j = 1; j < MASK_LAT; j++) dm_q[j] <= dm_q[j-1];
    end
  end

  assign tap       = lat - 1'b1;
  assign out_valid = v_q[tap];
  assign tap_data  = d_q[tap];

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      assign out_oe[g]           = out_valid & ~dm_q[MASK_LAT-1][g];
      assign out_data[g*8 +: 8]  = out_oe[g] ? tap_data[g*8 +: 8] : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/bce_page_mem.sv
`timescale 1ns/1ps
module bce_page_mem #(
  parameter  int COL_W  = 8,
  parameter  int DATA_W = 16,
  localparam int NB     = DATA_W / 8,
  localparam int DEPTH  = 1 << COL_W
) (
  input  logic              clk,
  input  logic [NB-1:0]     we,
  input  logic [COL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/burst_col_engine.sv
`timescale 1ns/1ps
module burst_col_engine
  import bce_pkg::*;
#(
  parameter  int COL_W    = 8,
  parameter  int DATA_W   = 16,
  parameter  int MAX_LAT  = 3,
  parameter  int MASK_LAT = 2,
  localparam int NB       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [COL_W-1:0]  addr,
  input  logic [NB-1:0]     dqm,
  input  logic [DATA_W-1:0] wdata,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic [NB-1:0]     wr_strobe,
  output logic              rd_valid,
  output logic [NB-1:0]     rd_oe,
  output logic [DATA_W-1:0] rdata
);
  mode_t             mode;
  logic              is_mode, is_rd, is_wr, is_pre;
  logic              beat, beat_wr, beat_rd;
  logic [DATA_W-1:0] mem_rdata;

  assign is_mode = (cmd == CMD_MODE);
  assign is_rd   = (cmd == CMD_READ);
  assign is_wr   = (cmd == CMD_WRITE);
  assign is_pre  = (cmd == CMD_PRE);

  bce_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (is_mode),
    .key   (addr[6:0]),
    .mode  (mode)
  );

  bce_col_gen #(.COL_W(COL_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_rd  (is_rd),
    .start_wr  (is_wr),
    .stop      (is_pre),
    .start_col (addr),
    .mode      (mode),
    .beat      (beat),
    .beat_wr   (beat_wr),
    .col       (col_addr)
  );

  assign col_valid = beat;
  assign beat_rd   = beat & ~beat_wr;
  assign wr_strobe = {NB{beat_wr}} & ~dqm;

  bce_page_mem #(.COL_W(COL_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (wr_strobe),
    .addr  (col_addr),
    .wdata (wdata),
    .rdata (mem_rdata)
  );

  bce_rd_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT), .MASK_LAT(MASK_LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (beat_rd),
    .in_data   (mem_rdata),
    .dqm       (dqm),
    .kill      (is_pre),
    .lat       (mode.cl),
    .out_valid (rd_valid),
    .out_oe    (rd_oe),
    .out_data  (rdata)
  );
endmodule

// File: rtl/bce_checker.sv
`timescale 1ns/1ps
module bce_checker
  import bce_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int NB    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd,
  input logic [COL_W-1:0] addr,
  input logic [NB-1:0]    dqm,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic [NB-1:0]    wr_strobe,
  input logic             rd_valid,
  input logic [NB-1:0]    rd_oe
);
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_start_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ || cmd == CMD_WRITE) |-> (col_valid && col_addr == addr));

  p_pre_no_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (!col_valid && wr_strobe == '0));

  p_strobe_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe != '0) |-> (col_valid && (wr_strobe & dqm) == '0));

  p_oe_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe != '0) |-> rd_valid);

  p_rd_mask_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && rd_valid) |-> ((rd_oe & $past(dqm, 2)) == '0));

  p_pre_stops_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && $past(cmd, 2) == CMD_PRE && $past(cmd, 1) != CMD_READ) |-> !rd_valid);
endmodule

bind burst_col_engine bce_checker #(.COL_W(COL_W), .NB(NB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd),
  .addr      (addr),
  .dqm       (dqm),
  .col_valid (col_valid),
  .col_addr  (col_addr),
  .wr_strobe (wr_strobe),
  .rd_valid  (rd_valid),
  .rd_oe     (rd_oe)
);

// File: tb/burst_col_engine_tb.sv
`timescale 1ns/1ps
module burst_col_engine_tb;
  localparam int LEN = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = '0;
  logic [7:0]  addr = '0;
  logic [1:0]  dqm = '0;
  logic [15:0] wdata = '0;
  logic        col_valid, rd_valid;
  logic [7:0]  col_addr;
  logic [1:0]  wr_strobe, rd_oe;
  logic [15:0] rdata;

  burst_col_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .dqm(dqm), .wdata(wdata),
    .col_valid(col_valid), .col_addr(col_addr), .wr_strobe(wr_strobe),
    .rd_valid(rd_valid), .rd_oe(rd_oe), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0]  s_cmd [LEN];
  logic [7:0]  s_addr[LEN];
  logic [1:0]  s_dqm [LEN];
  logic [15:0] s_wd  [LEN];
  logic        e_cv  [LEN];
  logic [7:0]  e_col [LEN];
  logic [1:0]  e_ws  [LEN];
  logic        e_rv  [LEN];
  logic [15:0] e_rd  [LEN];
  logic [15:0] shadow[256];
  string t_col, t_ws, t_rd, t_oe;

  task automatic chk(string tag, string what, int n, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, n, act, exp);
    end
  endtask

  function automatic logic [7:0] colf(logic [7:0] b, int k, int lg, bit full, bit ilv);
    logic [7:0] m, kk, o;
    m  = full ? 8'hFF : 8'((1 << lg) - 1);
    kk = 8'(k);
    o  = ilv ? (b ^ kk) : (b + kk);
    return (b & ~m) | (o & m);
  endfunction

  function automatic logic [15:0] pat(logic [7:0] c, logic [7:0] seed);
    return {c ^ seed, c + seed};
  endfunction

  task automatic clear();
    for (int n = 0; n < LEN; n++) begin
      s_cmd[n] = '0; s_addr[n] = '0; s_dqm[n] = '0; s_wd[n] = '0;
      e_cv[n] = 1'b0; e_col[n] = '0; e_ws[n] = '0; e_rv[n] = 1'b0; e_rd[n] = '0;
    end
  endtask

  task automatic add_burst(int n0, bit wr, logic [7:0] base, int nb, int lg, bit full,
                           bit ilv, int cl, logic [7:0] seed);
    s_cmd[n0]  = wr ? 3'd3 : 3'd2;
    s_addr[n0] = base;
    for (int k = 0; k < nb; k++) begin
      int n;
      logic [7:0] c;
      n = n0 + k;
      c = colf(base, k, lg, full, ilv);
      e_cv[n]  = 1'b1;
      e_col[n] = c;
      if (wr) begin
        s_wd[n] = pat(c, seed);
        e_ws[n] = ~s_dqm[n];
        for (int b = 0; b < 2; b++)
          if (!s_dqm[n][b]) shadow[c][b*8 +: 8] = s_wd[n][b*8 +: 8];
      end else begin
        e_rv[n+cl] = 1'b1;
        e_rd[n+cl] = shadow[c];
      end
    end
  endtask

  task automatic run(int len);
    for (int n = 0; n < len; n++) begin
      logic [1:0] oe_e;
      @(negedge clk);
      cmd = s_cmd[n]; addr = s_addr[n]; dqm = s_dqm[n]; wdata = s_wd[n];
      #1;
      chk(t_col, "col_valid", n, col_valid, e_cv[n]);
      if (e_cv[n]) chk(t_col, "col_addr", n, col_addr, e_col[n]);
      chk(t_ws, "wr_strobe", n, wr_strobe, e_ws[n]);
      chk(t_rd, "rd_valid", n, rd_valid, e_rv[n]);
      oe_e = !e_rv[n] ? 2'b00 : (n >= 2 ? ~s_dqm[n-2] : 2'b11);
      chk(t_oe, "rd_oe", n, rd_oe, oe_e);
      if (e_rv[n]) chk(t_rd, "rdata", n, rdata, e_rd[n] & {{8{oe_e[1]}}, {8{oe_e[0]}}});
    end
    @(negedge clk);
    cmd = '0; addr = '0; dqm = '0; wdata = '0;
  endtask

  task automatic mrs(logic [2:0] bl, bit bt, logic [2:0] cl);
    @(negedge clk);
    cmd = 3'd1; addr = {1'b0, cl, bt, bl}; dqm = '0;
    @(negedge clk);
    cmd = 3'd0; addr = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #900_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run still busy, expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs after reset
    #1;
    chk("R1", "col_valid", 0, col_valid, 0);
    chk("R1", "rd_valid", 0, rd_valid, 0);
    chk("R1", "wr_strobe", 0, wr_strobe, 0);
    chk("R1", "rd_oe", 0, rd_oe, 0);
    chk("R1", "rdata", 0, rdata, 0);

    // R1: default mode is length 4, sequential, latency 2
    t_col = "R1 R4 R5"; t_ws = "R8"; t_rd = "R1 R9"; t_oe = "R10";
    clear();
    add_burst(0, 1, 8'h30, 4, 2, 0, 0, 2, 8'h11);
    add_burst(6, 0, 8'h32, 4, 2, 0, 0, 2, 8'h00);
    run(14);

    // R7: whole-page write wraps across the page, then precharge
    mrs(3'b111, 0, 3'd3);
    t_col = "R7 R12"; t_ws = "R8"; t_rd = "R9"; t_oe = "R10";
    clear();
    add_burst(0, 1, 8'hF0, 260, 0, 1, 0, 3, 8'h00);
    s_cmd[260] = 3'd4;
    run(264);

    // R2 R5 R6 R9 R10: sweep order, length, start column, latency
    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int lg = 0; lg < 4; lg++) begin
        for (int si = 0; si < 4; si++) begin
          logic [7:0] st, seed;
          int bl;
          st   = (si == 0) ? 8'h00 : (si == 1) ? 8'h05 : (si == 2) ? 8'h3E : 8'hFB;
          seed = st ^ 8'(lg * 16 + ilv + 1);
          bl   = 1 << lg;
          t_col = ilv ? "R2 R4 R6" : "R2 R4 R5"; t_ws = "R8"; t_rd = "R9"; t_oe = "R10";
          mrs(3'(lg), 1'(ilv), 3'd2);
          clear();
          add_burst(0, 1, st, bl, lg, 0, 1'(ilv), 2, seed);
          run(bl + 3);
          for (int cl = 1; cl <= 3; cl++) begin
            mrs(3'(lg), 1'(ilv), 3'(cl));
            clear();
            for (int n = 0; n < 16; n++) s_dqm[n] = 2'(n * 3 + si);
            add_burst(0, 0, st, bl, lg, 0, 1'(ilv), cl, 8'h00);
            run(bl + cl + 3);
          end
        end
      end
    end

    // R8: write byte masks in the same cycle
    mrs(3'b010, 0, 3'd2);
    t_col = "R4 R8"; t_ws = "R8"; t_rd = "R8 R9"; t_oe = "R10";
    clear();
    s_dqm[0] = 2'b01; s_dqm[1] = 2'b10; s_dqm[2] = 2'b11; s_dqm[3] = 2'b00;
    add_burst(0, 1, 8'h41, 4, 2, 0, 0, 2, 8'h77);
    add_burst(6, 0, 8'h40, 4, 2, 0, 0, 2, 8'h00);
    run(14);

    // R11: bursts cut short by new commands, back to back
    mrs(3'b011, 0, 3'd2);
    t_col = "R11"; t_ws = "R11"; t_rd = "R11"; t_oe = "R10";
    clear();
    add_burst(0, 0, 8'h20, 3, 3, 0, 0, 2, 8'h00);
    add_burst(3, 0, 8'h48, 1, 3, 0, 0, 2, 8'h00);
    add_burst(4, 0, 8'h80, 8, 3, 0, 0, 2, 8'h00);
    run(16);

    // R7 R12: whole-page read cut by precharge, each latency
    for (int cl = 1; cl <= 3; cl++) begin
      mrs(3'b111, 0, 3'(cl));
      t_col = "R7 R12"; t_ws = "R12"; t_rd = "R12"; t_oe = "R10";
      clear();
      add_burst(0, 0, 8'hFE, 10, 0, 1, 0, cl, 8'h00);
      s_cmd[10] = 3'd4;
      for (int n = 12; n < 16; n++) e_rv[n] = 1'b0;
      run(16);
    end

    // R3: reserved mode keys leave length 2, latency 1 in force
    mrs(3'b001, 0, 3'd1);
    mrs(3'b100, 0, 3'd2);
    mrs(3'b111, 1, 3'd2);
    mrs(3'b010, 0, 3'd0);
    mrs(3'b010, 0, 3'b100);
    t_col = "R3"; t_ws = "R3"; t_rd = "R3"; t_oe = "R10";
    clear();
    add_burst(0, 0, 8'h11, 2, 1, 0, 0, 1, 8'h00);
    run(6);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule